// File: doc/BRIEF.md
# Speculative Prediction History Queue

This block keeps, for one hardware thread, the ordered list of branch predictions that are still in flight. The fetch stage writes one record per prediction at the young end. A record holds the sequence number, the branch PC, the predicted direction and target, and the call, return, used-stack, pushed-stack and indirect flags. It also holds the return-stack checkpoint (stack index and stacked target) that was current when the branch was predicted. The direction predictor, the target buffer and the return stack are outside the block. The queue reaches them through three command ports: a direction update, a target-buffer write and a stack repair (restore or pop).

The queue is driven by three requests. Retire drains records from the old end up to a sequence number and sends a final direction update for each one. Flush drops records from the young end that are younger than a sequence number, and sends each one's stack repair back to the return stack. Correct performs the same flush at the mispredicted branch and then rewrites that branch's surviving record in place. Every request walks one record per clock and raises `busy` until the walk finishes.

A small state machine controls the walks. It has five states. IDLE accepts requests. COMMIT runs the retire walk. SQUASH runs the flush walk. RES_SQ trims the young end before a correction. RES_FIX rewrites the corrected record. The transitions are: accept-squash (IDLE to SQUASH), accept-resolve (IDLE to RES_SQ), accept-commit (IDLE to COMMIT), walk-step (a state to itself while a record qualifies), walk-done (COMMIT or SQUASH to IDLE), trim-done (RES_SQ to RES_FIX) and fix-done (RES_FIX to IDLE).

Top module: `spec_hist_queue`

## Requirements
- R1: After reset the queue is empty. `busy`, `alloc_stall`, `upd_valid`, `stk_restore`, `stk_pop`, `btb_wr` and `resolve_err` are all low.
- R2: An allocation is accepted when `alloc_valid` is high and `alloc_stall` is low. The record goes to the young end. `alloc_stall` is high while DEPTH records are held, and an allocation offered then is not stored.
- R3: A retire to N removes records from the old end, oldest first, one per cycle, while the oldest number is unsigned less than or equal to N. Each removal pulses `upd_valid` with `upd_squash` low and with that record's PC and stored direction.
- R4: A flush to S removes records from the young end, youngest first, one per cycle, while the youngest number is unsigned greater than S.
- R5: For each record removed by a flush or a correction trim, the stack repair depends on the record's flags:
  - If used-stack is set, pulse `stk_restore` with the saved index and stacked target.
  - Otherwise, if both call and pushed-stack are set, pulse `stk_pop`.
  - Otherwise send no stack command.
- R6: A correction at S first trims exactly as R4 and R5. If the youngest remaining number then differs from S, it pulses `resolve_err` and changes nothing.
- R7: When the youngest remaining number equals S, the correction pulses `upd_valid` with `upd_squash` high, the record's PC and the actual direction. The stored direction becomes the actual direction, as a later retire shows.
- R8: For an actually-taken correction:
  - A return without used-stack gets used-stack set.
  - A record without the indirect flag pulses `btb_wr` with its PC and the corrected target.
- R9: For an actually-not-taken correction:
  - A record with used-stack pulses `stk_restore` and clears used-stack.
  - Otherwise, a call with pushed-stack pulses `stk_pop` and clears pushed-stack.
- R10: A correction that finds the queue empty after the trim sends no command and raises no error.
- R11: Requests are taken only while `busy` is low, and `busy` is high from the following cycle until the walk ends. Priority is flush, then correction, then retire, and a request that loses is dropped.
- R12: An allocation is accepted during a retire walk. `alloc_stall` is high during flush and correction walks, and also in the cycle a flush or correction is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | New prediction offered |
| alloc_seq | input | SEQ_W | Sequence number of the new prediction |
| alloc_pc | input | PC_W | Branch PC |
| alloc_taken | input | 1 | Predicted direction |
| alloc_target | input | PC_W | Predicted target |
| alloc_call | input | 1 | Branch is a call |
| alloc_ret | input | 1 | Branch is a return |
| alloc_used_stk | input | 1 | Target came from the return stack |
| alloc_pushed_stk | input | 1 | Branch pushed the return stack |
| alloc_indirect | input | 1 | Branch is indirect |
| alloc_stk_idx | input | SIDX_W | Saved return-stack index |
| alloc_stk_tgt | input | PC_W | Saved return-stack top target |
| alloc_stall | output | 1 | Allocation refused this cycle |
| commit_valid | input | 1 | Retire request |
| commit_seq | input | SEQ_W | Retire bound (inclusive) |
| squash_valid | input | 1 | Flush request |
| squash_seq | input | SEQ_W | Flush bound (records above it go) |
| resolve_valid | input | 1 | Correction request |
| resolve_seq | input | SEQ_W | Sequence number of the mispredicted branch |
| resolve_taken | input | 1 | Actual direction |
| resolve_target | input | PC_W | Corrected target |
| busy | output | 1 | A walk is in progress |
| upd_valid | output | 1 | Direction update command |
| upd_pc | output | PC_W | PC for the direction update |
| upd_taken | output | 1 | Direction for the update |
| upd_squash | output | 1 | Update comes from a correction |
| stk_restore | output | 1 | Return-stack restore command |
| stk_pop | output | 1 | Return-stack pop command |
| stk_idx | output | SIDX_W | Index for the restore |
| stk_tgt | output | PC_W | Target for the restore |
| btb_wr | output | 1 | Target-buffer write command |
| btb_pc | output | PC_W | PC for the target-buffer write |
| btb_target | output | PC_W | Target for the target-buffer write |
| resolve_err | output | 1 | Corrected record not found at the young end |

## Verification
A retire walk and an allocation can fall in the same cycle, one at each end of the ring. The bench builds a queue, starts a retire that drains only part of it, and offers a new record in the first walk cycle. It requires `alloc_stall` to stay low. It then retires everything and expects the surviving old records first and the new record last. The second collision is a flush and a retire offered in the same cycle. Here the bench expects only the flush's stack repairs, and a later full retire must still return the records the dropped retire would have taken.

// File: rtl/shq_pkg.sv
package shq_pkg;

    parameter int SEQ_W  = 8;
    parameter int PC_W   = 16;
    parameter int SIDX_W = 4;

    typedef struct packed {
        logic [SEQ_W-1:0]  seq;
        logic [PC_W-1:0]   pc;
        logic              taken;
        logic [PC_W-1:0]   target;
        logic              is_call;
        logic              is_ret;
        logic              used_stk;
        logic              pushed_stk;
        logic              indirect;
        logic [SIDX_W-1:0] stk_idx;
        logic [PC_W-1:0]   stk_tgt;
    } hist_ent_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COMMIT,
        ST_SQUASH,
        ST_RES_SQ,
        ST_RES_FIX
    } walk_st_e;

    typedef struct packed {
        logic restore;
        logic pop;
    } repair_t;

    // Undo action a record needs when it is thrown away from the young end.
    function automatic repair_t repair_for(hist_ent_t e);
        repair_t r;
        r.restore = e.used_stk;
        r.pop     = !e.used_stk && e.is_call && e.pushed_stk;
        return r;
    endfunction

endpackage

// File: rtl/shq_store.sv
module shq_store
    import shq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  hist_ent_t        push_ent,
    input  logic             pop_old,
    input  logic             pop_young,
    input  logic             fix_we,
    input  logic             fix_taken,
    input  logic             fix_used,
    input  logic             fix_pushed,
    output hist_ent_t        old_ent,
    output hist_ent_t        young_ent,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    hist_ent_t        ring [DEPTH];
    logic [PTR_W-1:0] head_q;
    logic [PTR_W-1:0] tail_q;
    logic [CNT_W-1:0] count_q;
    logic [PTR_W-1:0] young_idx;

    function automatic logic [PTR_W-1:0] ptr_inc(logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [PTR_W-1:0] ptr_dec(logic [PTR_W-1:0] p);
        return (p == '0) ? LAST : p - 1'b1;
    endfunction

    assign young_idx = ptr_dec(tail_q);
    assign old_ent   = ring[head_q];
    assign young_ent = ring[young_idx];
    assign count     = count_q;
    assign full      = (count_q == CNT_W'(DEPTH));
    assign empty     = (count_q == '0);

    always_ff @(posedge clk) begin
        if (push) begin
            ring[tail_q] <= push_ent;
        end
        if (fix_we) begin
            ring[young_idx].taken      <= fix_taken;
            ring[young_idx].used_stk   <= fix_used;
            ring[young_idx].pushed_stk <= fix_pushed;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            if (pop_old) begin
                head_q <= ptr_inc(head_q);
            end
            unique case ({push, pop_young})
                2'b10:   tail_q <= ptr_inc(tail_q);
                2'b01:   tail_q <= ptr_dec(tail_q);
                default: tail_q <= tail_q;
            endcase
            count_q <= count_q + CNT_W'(push) - CNT_W'(pop_old) - CNT_W'(pop_young);
        end
    end

    p_push_room_r2: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    p_pop_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_old || pop_young) |-> !empty);

    p_retire_shrinks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_old && !push) |=> count == $past(count) - 1'b1);

    p_fix_alone_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fix_we |-> !(push || pop_young || pop_old));

endmodule

// File: rtl/shq_ctrl.sv
module shq_ctrl
    import shq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic              full,
    input  logic              empty,
    input  hist_ent_t         old_ent,
    input  hist_ent_t         young_ent,
    input  logic              commit_valid,
    input  logic [SEQ_W-1:0]  commit_seq,
    input  logic              squash_valid,
    input  logic [SEQ_W-1:0]  squash_seq,
    input  logic              resolve_valid,
    input  logic [SEQ_W-1:0]  resolve_seq,
    input  logic              resolve_taken,
    input  logic [PC_W-1:0]   resolve_target,
    output logic              push,
    output logic              alloc_stall,
    output logic              pop_old,
    output logic              pop_young,
    output logic              fix_we,
    output logic              fix_taken,
    output logic              fix_used,
    output logic              fix_pushed,
    output logic              busy,
    output logic              upd_valid,
    output logic [PC_W-1:0]   upd_pc,
    output logic              upd_taken,
    output logic              upd_squash,
    output logic              stk_restore,
    output logic              stk_pop,
    output logic [SIDX_W-1:0] stk_idx,
    output logic [PC_W-1:0]   stk_tgt,
    output logic              btb_wr,
    output logic [PC_W-1:0]   btb_pc,
    output logic [PC_W-1:0]   btb_target,
    output logic              resolve_err
);

    walk_st_e         state_q, state_d;
    logic [SEQ_W-1:0] bound_q;
    logic             act_taken_q;
    logic [PC_W-1:0]  fix_target_q;
    logic             old_hit;
    logic             young_hit;
    logic             accept;
    repair_t          rep;
    logic             unused_fields;

    assign unused_fields = ^{old_ent.target, old_ent.is_call, old_ent.is_ret,
                             old_ent.used_stk, old_ent.pushed_stk, old_ent.indirect,
                             old_ent.stk_idx, old_ent.stk_tgt, young_ent.target,
                             young_ent.taken};

    assign old_hit   = !empty && (old_ent.seq <= bound_q);
    assign young_hit = !empty && (young_ent.seq > bound_q);
    assign accept    = (state_q == ST_IDLE) && (squash_valid || resolve_valid || commit_valid);
    assign busy      = (state_q != ST_IDLE);

    assign alloc_stall = full
                      || (state_q == ST_SQUASH) || (state_q == ST_RES_SQ) || (state_q == ST_RES_FIX)
                      || ((state_q == ST_IDLE) && (squash_valid || resolve_valid));
    assign push        = alloc_valid && !alloc_stall;

    assign pop_old   = (state_q == ST_COMMIT) && old_hit;
    assign pop_young = ((state_q == ST_SQUASH) || (state_q == ST_RES_SQ)) && young_hit;

    // Next state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (squash_valid)       state_d = ST_SQUASH;
                else if (resolve_valid) state_d = ST_RES_SQ;
                else if (commit_valid)  state_d = ST_COMMIT;
            end
            ST_COMMIT:  if (!old_hit)   state_d = ST_IDLE;
            ST_SQUASH:  if (!young_hit) state_d = ST_IDLE;
            ST_RES_SQ:  if (!young_hit) state_d = ST_RES_FIX;
            ST_RES_FIX: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register and request capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            bound_q      <= '0;
            act_taken_q  <= 1'b0;
            fix_target_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                if (squash_valid) begin
                    bound_q <= squash_seq;
                end else if (resolve_valid) begin
                    bound_q      <= resolve_seq;
                    act_taken_q  <= resolve_taken;
                    fix_target_q <= resolve_target;
                end else begin
                    bound_q <= commit_seq;
                end
            end
        end
    end

    // Commands.
    always_comb begin
        upd_valid   = 1'b0;
        upd_taken   = 1'b0;
        upd_squash  = 1'b0;
        stk_restore = 1'b0;
        stk_pop     = 1'b0;
        btb_wr      = 1'b0;
        resolve_err = 1'b0;
        fix_we      = 1'b0;
        fix_taken   = act_taken_q;
        fix_used    = young_ent.used_stk;
        fix_pushed  = young_ent.pushed_stk;
        rep         = repair_for(young_ent);
        upd_pc      = (state_q == ST_COMMIT) ? old_ent.pc : young_ent.pc;
        stk_idx     = young_ent.stk_idx;
        stk_tgt     = young_ent.stk_tgt;
        btb_pc      = young_ent.pc;
        btb_target  = fix_target_q;
        unique case (state_q)
            ST_COMMIT: begin
                if (old_hit) begin
                    upd_valid = 1'b1;
                    upd_taken = old_ent.taken;
                end
            end
            ST_SQUASH, ST_RES_SQ: begin
                if (young_hit) begin
                    stk_restore = rep.restore;
                    stk_pop     = rep.pop;
                end
            end
            ST_RES_FIX: begin
                if (!empty) begin
                    if (young_ent.seq != bound_q) begin
                        resolve_err = 1'b1;
                    end else begin
                        upd_valid  = 1'b1;
                        upd_taken  = act_taken_q;
                        upd_squash = 1'b1;
                        fix_we     = 1'b1;
                        if (act_taken_q) begin
                            if (young_ent.is_ret && !young_ent.used_stk) fix_used = 1'b1;
                            if (!young_ent.indirect) btb_wr = 1'b1;
                        end else if (young_ent.used_stk) begin
                            stk_restore = 1'b1;
                            fix_used    = 1'b0;
                        end else if (young_ent.is_call && young_ent.pushed_stk) begin
                            stk_pop    = 1'b1;
                            fix_pushed = 1'b0;
                        end
                    end
                end
            end
            default: ;
        endcase
    end

    p_fix_then_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RES_FIX) |=> (state_q == ST_IDLE));

    p_no_alloc_in_flush_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_SQUASH) || (state_q == ST_RES_SQ)) |-> !push);

    p_one_repair_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({stk_restore, stk_pop}));

    p_btb_on_taken_r8: assert property (@(posedge clk) disable iff (!rst_n)
        btb_wr |-> (act_taken_q && upd_squash));

    p_busy_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(upd_valid || stk_restore || stk_pop || btb_wr || resolve_err));

endmodule

// File: rtl/spec_hist_queue.sv
module spec_hist_queue
    import shq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [SEQ_W-1:0]  alloc_seq,
    input  logic [PC_W-1:0]   alloc_pc,
    input  logic              alloc_taken,
    input  logic [PC_W-1:0]   alloc_target,
    input  logic              alloc_call,
    input  logic              alloc_ret,
    input  logic              alloc_used_stk,
    input  logic              alloc_pushed_stk,
    input  logic              alloc_indirect,
    input  logic [SIDX_W-1:0] alloc_stk_idx,
    input  logic [PC_W-1:0]   alloc_stk_tgt,
    output logic              alloc_stall,
    input  logic              commit_valid,
    input  logic [SEQ_W-1:0]  commit_seq,
    input  logic              squash_valid,
    input  logic [SEQ_W-1:0]  squash_seq,
    input  logic              resolve_valid,
    input  logic [SEQ_W-1:0]  resolve_seq,
    input  logic              resolve_taken,
    input  logic [PC_W-1:0]   resolve_target,
    output logic              busy,
    output logic              upd_valid,
    output logic [PC_W-1:0]   upd_pc,
    output logic              upd_taken,
    output logic              upd_squash,
    output logic              stk_restore,
    output logic              stk_pop,
    output logic [SIDX_W-1:0] stk_idx,
    output logic [PC_W-1:0]   stk_tgt,
    output logic              btb_wr,
    output logic [PC_W-1:0]   btb_pc,
    output logic [PC_W-1:0]   btb_target,
    output logic              resolve_err
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    hist_ent_t        new_ent;
    hist_ent_t        old_ent;
    hist_ent_t        young_ent;
    logic [CNT_W-1:0] count;
    logic             full;
    logic             empty;
    logic             push;
    logic             pop_old;
    logic             pop_young;
    logic             fix_we;
    logic             fix_taken;
    logic             fix_used;
    logic             fix_pushed;

    always_comb begin
        new_ent.seq        = alloc_seq;
        new_ent.pc         = alloc_pc;
        new_ent.taken      = alloc_taken;
        new_ent.target     = alloc_target;
        new_ent.is_call    = alloc_call;
        new_ent.is_ret     = alloc_ret;
        new_ent.used_stk   = alloc_used_stk;
        new_ent.pushed_stk = alloc_pushed_stk;
        new_ent.indirect   = alloc_indirect;
        new_ent.stk_idx    = alloc_stk_idx;
        new_ent.stk_tgt    = alloc_stk_tgt;
    end

    shq_store #(.DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push),
        .push_ent   (new_ent),
        .pop_old    (pop_old),
        .pop_young  (pop_young),
        .fix_we     (fix_we),
        .fix_taken  (fix_taken),
        .fix_used   (fix_used),
        .fix_pushed (fix_pushed),
        .old_ent    (old_ent),
        .young_ent  (young_ent),
        .count      (count),
        .full       (full),
        .empty      (empty)
    );

    shq_ctrl u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .alloc_valid    (alloc_valid),
        .full           (full),
        .empty          (empty),
        .old_ent        (old_ent),
        .young_ent      (young_ent),
        .commit_valid   (commit_valid),
        .commit_seq     (commit_seq),
        .squash_valid   (squash_valid),
        .squash_seq     (squash_seq),
        .resolve_valid  (resolve_valid),
        .resolve_seq    (resolve_seq),
        .resolve_taken  (resolve_taken),
        .resolve_target (resolve_target),
        .push           (push),
        .alloc_stall    (alloc_stall),
        .pop_old        (pop_old),
        .pop_young      (pop_young),
        .fix_we         (fix_we),
        .fix_taken      (fix_taken),
        .fix_used       (fix_used),
        .fix_pushed     (fix_pushed),
        .busy           (busy),
        .upd_valid      (upd_valid),
        .upd_pc         (upd_pc),
        .upd_taken      (upd_taken),
        .upd_squash     (upd_squash),
        .stk_restore    (stk_restore),
        .stk_pop        (stk_pop),
        .stk_idx        (stk_idx),
        .stk_tgt        (stk_tgt),
        .btb_wr         (btb_wr),
        .btb_pc         (btb_pc),
        .btb_target     (btb_target),
        .resolve_err    (resolve_err)
    );

    p_full_stalls_r2: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> alloc_stall);

    p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

endmodule

// File: tb/spec_hist_queue_test.sv
`timescale 1ns/1ps
module spec_hist_queue_test;

    localparam int DEPTH = 8;

    typedef struct packed {
        logic [7:0]  seq;
        logic [15:0] pc;
        logic        tk;
        logic [15:0] tgt;
        logic        call;
        logic        ret;
        logic        used;
        logic        pushed;
        logic        ind;
        logic [3:0]  sidx;
        logic [15:0] stgt;
    } m_ent_t;

    typedef struct packed {
        logic        upd;
        logic [15:0] upd_pc;
        logic        upd_tk;
        logic        upd_sq;
        logic        rst;
        logic        pop;
        logic [3:0]  idx;
        logic [15:0] tgt;
        logic        btb;
        logic [15:0] bpc;
        logic [15:0] btgt;
        logic        err;
    } ev_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_valid = 1'b0;
    logic [7:0]  alloc_seq = '0;
    logic [15:0] alloc_pc = '0;
    logic        alloc_taken = 1'b0;
    logic [15:0] alloc_target = '0;
    logic        alloc_call = 1'b0;
    logic        alloc_ret = 1'b0;
    logic        alloc_used_stk = 1'b0;
    logic        alloc_pushed_stk = 1'b0;
    logic        alloc_indirect = 1'b0;
    logic [3:0]  alloc_stk_idx = '0;
    logic [15:0] alloc_stk_tgt = '0;
    logic        alloc_stall;
    logic        commit_valid = 1'b0;
    logic [7:0]  commit_seq = '0;
    logic        squash_valid = 1'b0;
    logic [7:0]  squash_seq = '0;
    logic        resolve_valid = 1'b0;
    logic [7:0]  resolve_seq = '0;
    logic        resolve_taken = 1'b0;
    logic [15:0] resolve_target = '0;
    logic        busy;
    logic        upd_valid;
    logic [15:0] upd_pc;
    logic        upd_taken;
    logic        upd_squash;
    logic        stk_restore;
    logic        stk_pop;
    logic [3:0]  stk_idx;
    logic [15:0] stk_tgt;
    logic        btb_wr;
    logic [15:0] btb_pc;
    logic [15:0] btb_target;
    logic        resolve_err;

    int checks = 0;
    int errors = 0;

    m_ent_t mq[$];
    ev_t    eq[$];
    ev_t    gq[$];

    always #2.5 clk = ~clk;

    spec_hist_queue #(.DEPTH(DEPTH)) uut (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic m_ent_t mk(input logic [7:0] seq, input logic tk, input logic [4:0] fl);
        m_ent_t e;
        e.seq    = seq;
        e.pc     = 16'h1000 + 16'(seq) * 16'd4;
        e.tk     = tk;
        e.tgt    = 16'h8000 + 16'(seq);
        e.call   = fl[0];
        e.ret    = fl[1];
        e.used   = fl[2];
        e.pushed = fl[3];
        e.ind    = fl[4];
        e.sidx   = seq[3:0] ^ 4'h5;
        e.stgt   = 16'h4000 + 16'(seq) * 16'd3;
        return e;
    endfunction

    function automatic ev_t sample();
        ev_t e = '0;
        if (upd_valid) begin
            e.upd = 1'b1; e.upd_pc = upd_pc; e.upd_tk = upd_taken; e.upd_sq = upd_squash;
        end
        if (stk_restore) begin
            e.rst = 1'b1; e.idx = stk_idx; e.tgt = stk_tgt;
        end
        if (stk_pop) e.pop = 1'b1;
        if (btb_wr) begin
            e.btb = 1'b1; e.bpc = btb_pc; e.btgt = btb_target;
        end
        if (resolve_err) e.err = 1'b1;
        return e;
    endfunction

    // Expected commands from the requirements.
    function automatic void exp_commit(input logic [7:0] n);
        ev_t e;
        while (mq.size() > 0 && mq[0].seq <= n) begin
            e = '0; e.upd = 1'b1; e.upd_pc = mq[0].pc; e.upd_tk = mq[0].tk;
            eq.push_back(e);
            void'(mq.pop_front());
        end
    endfunction

    function automatic void exp_squash(input logic [7:0] s);
        ev_t e;
        m_ent_t y;
        while (mq.size() > 0 && mq[mq.size()-1].seq > s) begin
            y = mq.pop_back();
            e = '0;
            if (y.used) begin
                e.rst = 1'b1; e.idx = y.sidx; e.tgt = y.stgt;
            end else if (y.call && y.pushed) begin
                e.pop = 1'b1;
            end
            if (e != '0) eq.push_back(e);
        end
    endfunction

    function automatic void exp_resolve(input logic [7:0] s, input logic t, input logic [15:0] tg);
        ev_t e = '0;
        m_ent_t y;
        exp_squash(s);
        if (mq.size() == 0) return;
        y = mq[mq.size()-1];
        if (y.seq != s) begin
            e.err = 1'b1;
        end else begin
            e.upd = 1'b1; e.upd_pc = y.pc; e.upd_tk = t; e.upd_sq = 1'b1;
            if (t) begin
                if (y.ret && !y.used) y.used = 1'b1;
                if (!y.ind) begin
                    e.btb = 1'b1; e.bpc = y.pc; e.btgt = tg;
                end
            end else if (y.used) begin
                e.rst = 1'b1; e.idx = y.sidx; e.tgt = y.stgt; y.used = 1'b0;
            end else if (y.call && y.pushed) begin
                e.pop = 1'b1; y.pushed = 1'b0;
            end
            y.tk = t;
            mq[mq.size()-1] = y;
        end
        eq.push_back(e);
    endfunction

    task automatic do_alloc(input m_ent_t e, output bit acc);
        alloc_valid = 1'b1;
        alloc_seq = e.seq; alloc_pc = e.pc; alloc_taken = e.tk; alloc_target = e.tgt;
        alloc_call = e.call; alloc_ret = e.ret; alloc_used_stk = e.used;
        alloc_pushed_stk = e.pushed; alloc_indirect = e.ind;
        alloc_stk_idx = e.sidx; alloc_stk_tgt = e.stgt;
        #0.1;
        acc = !alloc_stall;
        @(posedge clk);
        if (acc) mq.push_back(e);
        @(negedge clk);
        alloc_valid = 1'b0;
    endtask

    // op: 0 retire, 1 flush, 2 correction, 3 flush and retire together
    task automatic run_op(input int op, input logic [7:0] s, input logic t,
                          input logic [15:0] tg, input string req,
                          input bit mid_alloc, input m_ent_t ae);
        bit first = 1'b1;
        bit acc;
        int guard = 0;
        ev_t e;
        eq.delete();
        gq.delete();
        if (op == 0) exp_commit(s);
        else if (op == 2) exp_resolve(s, t, tg);
        else exp_squash(s);
        commit_valid  = (op == 0 || op == 3);
        commit_seq    = (op == 3) ? 8'hFF : s;
        squash_valid  = (op == 1 || op == 3);
        squash_seq    = s;
        resolve_valid = (op == 2);
        resolve_seq   = s;
        resolve_taken = t;
        resolve_target = tg;
        @(posedge clk);
        @(negedge clk);
        commit_valid = 1'b0; squash_valid = 1'b0; resolve_valid = 1'b0;
        chk(busy == 1'b1, "R11", "busy after request", 80'(busy), 80'(1));
        while (busy && guard < 100) begin
            acc = 1'b0;
            if (first && op != 0) begin
                chk(alloc_stall == 1'b1, "R12", "stall in flush walk", 80'(alloc_stall), 80'(1));
            end
            if (first && mid_alloc) begin
                alloc_valid = 1'b1;
                alloc_seq = ae.seq; alloc_pc = ae.pc; alloc_taken = ae.tk; alloc_target = ae.tgt;
                alloc_call = ae.call; alloc_ret = ae.ret; alloc_used_stk = ae.used;
                alloc_pushed_stk = ae.pushed; alloc_indirect = ae.ind;
                alloc_stk_idx = ae.sidx; alloc_stk_tgt = ae.stgt;
                #0.1;
                acc = !alloc_stall;
                chk(acc, "R12", "alloc during retire walk", 80'(alloc_stall), 80'(0));
            end
            e = sample();
            if (e != '0) gq.push_back(e);
            @(posedge clk);
            if (acc) mq.push_back(ae);
            @(negedge clk);
            alloc_valid = 1'b0;
            first = 1'b0;
            guard++;
        end
        chk(gq.size() == eq.size(), req, "command count", 80'(gq.size()), 80'(eq.size()));
        for (int i = 0; i < eq.size() && i < gq.size(); i++) begin
            chk(gq[i] == eq[i], req, $sformatf("command %0d", i), 80'(gq[i]), 80'(eq[i]));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        bit acc;
        m_ent_t none = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #0.1;
        // R1 reset state
        chk(!busy && !alloc_stall && !upd_valid && !stk_restore && !stk_pop && !btb_wr && !resolve_err,
            "R1", "idle outputs after reset",
            80'({busy, alloc_stall, upd_valid, stk_restore, stk_pop, btb_wr, resolve_err}), 80'(0));
        run_op(0, 8'hFF, 1'b0, '0, "R1", 1'b0, none);

        // R2 fill to depth, stall when full, then R3 drain
        for (int i = 0; i < DEPTH; i++) begin
            do_alloc(mk(8'(10 * (i + 1)), i[0], 5'd0), acc);
            chk(acc, "R2", "alloc accepted", 80'(acc), 80'(1));
        end
        #0.1;
        chk(alloc_stall, "R2", "stall when full", 80'(alloc_stall), 80'(1));
        do_alloc(mk(8'd95, 1'b1, 5'd0), acc);
        chk(!acc, "R2", "alloc refused when full", 80'(acc), 80'(0));
        run_op(0, 8'd35, 1'b0, '0, "R3", 1'b0, none);
        run_op(0, 8'd200, 1'b0, '0, "R3", 1'b0, none);

        // R4 R5 flush sweep over all flag patterns
        for (int g = 0; g < 8; g++) begin
            for (int i = 0; i < 4; i++) begin
                do_alloc(mk(8'(100 + i), 1'b0, 5'(g * 4 + i)), acc);
            end
            run_op(1, 8'(99 + (g % 3)), 1'b0, '0, "R5", 1'b0, none);
            run_op(1, 8'd0, 1'b0, '0, "R4", 1'b0, none);
        end

        // R6..R9 correction sweep; later flush exposes rewritten flags
        for (int t = 0; t < 2; t++) begin
            for (int f = 0; f < 32; f++) begin
                do_alloc(mk(8'd50, 1'b0, 5'(f)), acc);
                do_alloc(mk(8'd60, 1'b1, 5'b00100), acc);
                run_op(2, 8'd50, t[0], 16'hB000 + 16'(f), (t == 1) ? "R8" : "R9", 1'b0, none);
                run_op(1, 8'd49, 1'b0, '0, "R8", 1'b0, none);
            end
        end

        // R7 stored direction overwritten, seen at retire
        do_alloc(mk(8'd5, 1'b0, 5'd0), acc);
        run_op(2, 8'd5, 1'b1, 16'hCAFE, "R7", 1'b0, none);
        run_op(0, 8'd5, 1'b0, '0, "R7", 1'b0, none);

        // R6 mismatch
        do_alloc(mk(8'd70, 1'b1, 5'd0), acc);
        do_alloc(mk(8'd80, 1'b0, 5'b01001), acc);
        run_op(2, 8'd75, 1'b0, 16'h1234, "R6", 1'b0, none);
        run_op(0, 8'd255, 1'b0, '0, "R6", 1'b0, none);

        // R10 correction on empty queue
        run_op(2, 8'd9, 1'b1, 16'h2222, "R10", 1'b0, none);

        // R11 flush and retire together: retire dropped
        do_alloc(mk(8'd20, 1'b1, 5'b00100), acc);
        do_alloc(mk(8'd30, 1'b0, 5'b00100), acc);
        do_alloc(mk(8'd40, 1'b1, 5'b01001), acc);
        run_op(3, 8'd25, 1'b0, '0, "R11", 1'b0, none);
        run_op(0, 8'd255, 1'b0, '0, "R11", 1'b0, none);

        // R12 allocation alongside a retire walk
        do_alloc(mk(8'd10, 1'b0, 5'd0), acc);
        do_alloc(mk(8'd20, 1'b1, 5'd0), acc);
        do_alloc(mk(8'd30, 1'b0, 5'd0), acc);
        run_op(0, 8'd25, 1'b0, '0, "R12", 1'b1, mk(8'd40, 1'b1, 5'd0));
        run_op(0, 8'd255, 1'b0, '0, "R12", 1'b0, none);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule